// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two W-bit two's-complement numbers and returns their 2W-bit signed product. It retires one bit of the multiplier per clock cycle. A single (2W+1)-bit working register holds the growing upper partial product, the multiplier bits that are still to be consumed, and one guard bit below them. At every step the lowest multiplier bit and the guard bit select adding the multiplicand to the upper part, subtracting it, or leaving the register alone. The whole register then shifts one place right, and the top bit is copied into the vacated position.

A client waits for `busy` to be low, drives the operands and raises `start` for one cycle. Exactly W cycles after `busy` rises, `done` pulses for one cycle and `product` carries the result. `product` keeps that value until the next multiplication completes. Signed operands need no correction step, including the most negative value.

Top module: `booth_mul_seq`

## Requirements
- R1: After synchronous reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` pulse seen while `busy` is 0 captures both operands, and `busy` is 1 from the next cycle on.
- R3: When the operands are captured at clock edge k, `done` is 1 only between edges k+W and k+W+1, and `busy` is 0 from edge k+W on.
- R4: The step action is decoded from the pair {current multiplier bit, guard bit}. 01 adds the multiplicand to the upper part, 10 subtracts it, and 00 or 11 does nothing. The guard bit starts at 0. As a result, for non-negative operands `product` equals their product; for W=4, 0010 × 0110 = 0000_1100.
- R5: A negative multiplicand or multiplier gives the correct signed product with no extra step; for W=4, 0010 × 1101 = 1111_1010.
- R6: Add and subtract are done at W+1 bits, so the most negative multiplicand gives exact results: min × min = 2^(2W-2) and min × (−1) = 2^(W-1).
- R7: A `start` pulse while `busy` is 1 is ignored. The running multiplication finishes on schedule with the operands captured at its own start.
- R8: `product` does not change between two completions.
- R9: A zero operand gives 0, and all-ones × all-ones (−1 × −1) gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication |
| multiplicand | input | W | Signed multiplicand, sampled on an accepted start |
| multiplier | input | W | Signed multiplier, sampled on an accepted start |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product of the last completed multiplication |

## Verification
The bench builds two instances, one with W=8 and one with W=4. The W=4 copy makes the short hand-traceable cases directly checkable: the positive and negative-multiplier examples, and the corner where the most negative multiplicand meets itself. The W=8 copy keeps each run to a few cycles, so several hundred random signed operand pairs fit in the run. It also covers the full set of extreme pairs, a mid-run start collision and the exact cycle of the `done` pulse.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    ACT_NOP = 2'd0,
    ACT_ADD = 2'd1,
    ACT_SUB = 2'd2
  } booth_act_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic       cur_bit,
  input  logic       guard_bit,
  output booth_act_e act
);
  // R4: 01 -> add, 10 -> subtract, 00/11 -> nothing
  always_comb begin
    case ({cur_bit, guard_bit})
      2'b01:   act = ACT_ADD;
      2'b10:   act = ACT_SUB;
      default: act = ACT_NOP;
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W:0]  acc_i,
  input  logic [W-1:0]  mcand,
  input  booth_act_e    act,
  output logic [2*W:0]  acc_o
);
  localparam int HI_LSB = W + 1;
  localparam int TOP    = 2 * W;

  logic [W:0] hi_ext;
  logic [W:0] m_ext;
  logic [W:0] sum;

  // R6: widen by one bit so the shifted-in sign is always the true sign
  always_comb begin
    hi_ext = {acc_i[TOP], acc_i[TOP:HI_LSB]};
    m_ext  = {mcand[W-1], mcand};
    case (act)
      ACT_ADD: sum = hi_ext + m_ext;
      ACT_SUB: sum = hi_ext - m_ext;
      default: sum = hi_ext;
    endcase
  end

  // arithmetic right shift of the whole register, guard bit included
  assign acc_o = {sum, acc_i[W:1]};
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic load,
  output logic last
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [CW-1:0] cnt;

  assign load = start && !busy;        // R7: start ignored while busy
  assign last = busy && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      busy <= !last;
      cnt  <= cnt + 1'b1;
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST_CNT));
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cnt == '0));
  p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int AW = 2 * W + 1;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_nxt;
  logic [W-1:0]  mcand_q;
  logic          load;
  logic          last;
  booth_act_e    act;

  booth_seq_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .load  (load),
    .last  (last)
  );

  booth_recode u_rec (
    .cur_bit   (acc_q[1]),
    .guard_bit (acc_q[0]),
    .act       (act)
  );

  booth_step #(.W(W)) u_step (
    .acc_i (acc_q),
    .mcand (mcand_q),
    .act   (act),
    .acc_o (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        acc_q   <= {{W{1'b0}}, multiplier, 1'b0};
        mcand_q <= multiplicand;
      end else if (busy) begin
        acc_q <= acc_nxt;
      end
      if (last) product <= acc_nxt[AW-1:1];
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
  p_mcand_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mcand_q));
endmodule

// File: tb/sim_booth_mul_seq.sv
module sim_booth_mul_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0;
  int failures = 0;

  // W=8 instance
  logic        st8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        busy8, done8;
  logic [15:0] p8;
  booth_mul_seq #(.W(8)) u0 (
    .clk(clk), .rst(rst), .start(st8), .multiplicand(a8), .multiplier(b8),
    .busy(busy8), .done(done8), .product(p8));

  // W=4 instance
  logic        st4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        busy4, done4;
  logic [7:0]  p4;
  booth_mul_seq #(.W(4)) u1 (
    .clk(clk), .rst(rst), .start(st4), .multiplicand(a4), .multiplier(b4),
    .busy(busy4), .done(done4), .product(p4));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one W=8 multiplication; optionally a colliding start mid-run
  task automatic mul8(input logic [7:0] a, input logic [7:0] b, input string req, input bit disturb);
    logic signed [15:0] exp;
    logic [15:0] held;
    bit early;
    exp = $signed(a) * $signed(b);
    early = 1'b0;
    @(negedge clk);
    a8 = a; b8 = b; st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0;
    chk(busy8 === 1'b1, "R2 busy after start", longint'(busy8), 1);
    for (int i = 1; i < 8; i++) begin
      if (disturb && i == 3) begin st8 = 1'b1; a8 = ~a; b8 = b + 8'd1; end
      @(negedge clk);
      st8 = 1'b0;
      if (done8 !== 1'b0) early = 1'b1;
    end
    @(negedge clk);
    chk(!early && done8 === 1'b1 && busy8 === 1'b0, "R3 done timing",
        longint'({early, done8, busy8}), 2);
    chk(p8 === exp, req, longint'(p8), longint'(exp));
    held = p8;
    @(negedge clk);
    chk(done8 === 1'b0 && p8 === held, "R8 hold and single done pulse",
        longint'({done8, p8}), longint'({1'b0, held}));
  endtask

  task automatic mul4(input logic [3:0] a, input logic [3:0] b, input string req);
    logic signed [7:0] exp;
    exp = $signed(a) * $signed(b);
    @(negedge clk);
    a4 = a; b4 = b; st4 = 1'b1;
    @(negedge clk);
    st4 = 1'b0;
    repeat (4) @(negedge clk);
    chk(done4 === 1'b1 && p4 === exp, req, longint'(p4), longint'(exp));
  endtask

  task automatic t_reset();
    chk(busy8 === 0 && done8 === 0 && p8 === 0, "R1 reset W8", longint'({busy8, done8, p8}), 0);
    chk(busy4 === 0 && done4 === 0 && p4 === 0, "R1 reset W4", longint'({busy4, done4, p4}), 0);
  endtask

  task automatic t_examples();
    mul4(4'b0010, 4'b0110, "R4 0010x0110");
    mul4(4'b0010, 4'b1101, "R5 0010x1101");
    mul4(4'b1000, 4'b1000, "R6 min x min W4");
    mul4(4'b1000, 4'b1111, "R6 min x -1 W4");
  endtask

  task automatic t_extremes();
    mul8(8'h80, 8'h80, "R6 min x min", 1'b0);
    mul8(8'h80, 8'hFF, "R6 min x -1", 1'b0);
    mul8(8'hFF, 8'h80, "R6 -1 x min", 1'b0);
    mul8(8'h00, 8'h5A, "R9 zero multiplicand", 1'b0);
    mul8(8'hA5, 8'h00, "R9 zero multiplier", 1'b0);
    mul8(8'hFF, 8'hFF, "R9 all ones", 1'b0);
    mul8(8'h7F, 8'h7F, "R4 max x max", 1'b0);
    mul8(8'h7F, 8'h80, "R5 max x min", 1'b0);
  endtask

  task automatic t_collision();
    mul8(8'h13, 8'hE7, "R7 start during busy ignored", 1'b1);
    mul8(8'h80, 8'h55, "R7 start during busy ignored, min mcand", 1'b1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      if (a[7] || b[7]) mul8(a, b, "R5 random signed", 1'b0);
      else              mul8(a, b, "R4 random non-negative", 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_examples();
    t_extremes();
    t_collision();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule